// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects 32 level-sensitive interrupt request lines from peripherals and delivers them to a processor as two interrupt outputs. Each request line passes through a two-stage synchronizer. Software controls the block through a small register bus. It can enable or disable individual sources with separate set and clear writes, and it can steer each source to either output. It can also read the unmasked request levels and a masked view for each output.

The top bit of the enable mask is a global gate. While that bit is clear, neither output can assert. The block also provides a dispatch hint for the first output: the number of the lowest-numbered source that is pending on it, together with a flag that reads low when nothing is pending. A dispatcher treats that low flag as a spurious entry. The performance-counter line, source 9, is handled in exactly the same way as every other source.

Top module: `irq_router`

## Requirements
- R1: After reset the enable mask and the route register read 0, both CPU outputs are low and the dispatch flag is low.
- R2: Reading offset 0x30 returns the request inputs as they were two clock edges earlier (two-stage synchronizer).
- R3: A write to offset 0x34 sets every enable bit written as 1 and leaves the bits written as 0 unchanged; reading offset 0x34 returns the enable mask.
- R4: A write to offset 0x38 clears every enable bit written as 1, and writing all ones clears the whole mask; offset 0x38 reads 0.
- R5: Offset 0x20 holds the route register, read/write. A route bit of 0 sends that source to output 0, and a route bit of 1 sends it to output 1.
- R6: Offset 0x00 reads raw AND enable AND NOT route, and offset 0x04 reads raw AND enable AND route. Writes to these two offsets have no effect.
- R7: cpu_irq[n] is asserted one clock after the masked view for output n is nonzero while enable bit 31 is set.
- R8: While enable bit 31 is clear, both CPU outputs are low one clock later, whatever the sources and the other enables are.
- R9: disp_valid is high exactly when the masked view for output 0 is nonzero, and disp_idx is then the position of its lowest set bit.
- R10: Sources are level-sensitive. A masked bit and its output follow the input level and drop once the input is released, with no latching.
- R11: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Level request lines, one per source |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read during the strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, 0 otherwise |
| cpu_irq | output | 2 | Registered interrupt requests to the processor |
| disp_valid | output | 1 | A source is pending on output 0 |
| disp_idx | output | 5 | Lowest pending source number on output 0 |

## Verification
Sparse patterns with a low bit and source 9 set check that the dispatch index picks the lowest pending bit. They also show that moving that bit to output 1 moves the index up to 9. A walking single bit across all 32 positions, followed by all-ones and top-bit-only patterns, separates a correct priority encoder from one that is off by one or scans in reverse. Toggling the global bit with the sources held separates gating from masking. Dropping a level while it is enabled checks that nothing is latched. Writes to the masked-view offsets and to unmapped offsets check that those writes are discarded.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MST0  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MST1  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h38;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MST0,
        RG_MST1,
        RG_ROUTE,
        RG_RAW,
        RG_ENSET,
        RG_ENCLR
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        case (a)
            OFS_MST0:  r = RG_MST0;
            OFS_MST1:  r = RG_MST1;
            OFS_ROUTE: r = RG_ROUTE;
            OFS_RAW:   r = RG_RAW;
            OFS_ENSET: r = RG_ENSET;
            OFS_ENCLR: r = RG_ENCLR;
            default:   r = RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] raw_o
);
    localparam int unsigned CNT_W = $clog2(STAGES + 1) + 1;

    typedef struct packed {
        logic [STAGES-1:0][NSRC-1:0] stg;
        logic [CNT_W-1:0]            age;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = src_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
        if (st_q.age < CNT_W'(STAGES)) begin
            st_d.age = st_q.age + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.stg[STAGES-1];

    // R2: raw view equals the input two edges back (checked for the default depth)
    generate
        if (STAGES == 2) begin : g_chk2
            p_raw_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.age >= CNT_W'(2)) |-> (raw_o == $past(src_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
    import irqr_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   mask0_i,
    input  logic [NSRC-1:0]   mask1_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   route_o,
    output logic [NSRC-1:0]   rdata_o
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] route;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e which;
    logic     do_wr, do_rd;

    always_comb begin
        which = decode_ofs(addr_i);
        do_wr = sel_i && wr_i;
        do_rd = sel_i && !wr_i;
        cfg_d = cfg_q;
        if (do_wr) begin
            case (which)
                RG_ENSET: cfg_d.en    = cfg_q.en | wdata_i;
                RG_ENCLR: cfg_d.en    = cfg_q.en & ~wdata_i;
                RG_ROUTE: cfg_d.route = wdata_i;
                default:  cfg_d = cfg_q;
            endcase
        end
        rdata_o = '0;
        if (do_rd) begin
            case (which)
                RG_MST0:  rdata_o = mask0_i;
                RG_MST1:  rdata_o = mask1_i;
                RG_ROUTE: rdata_o = cfg_q.route;
                RG_RAW:   rdata_o = raw_i;
                RG_ENSET: rdata_o = cfg_q.en;
                default:  rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o    = cfg_q.en;
    assign route_o = cfg_q.route;

    p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && addr_i == OFS_ENSET)
        |=> ((en_o & $past(wdata_i)) == $past(wdata_i))
            && ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i))));

    p_enclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && addr_i == OFS_ENCLR)
        |=> ((en_o & $past(wdata_i)) == '0));

    p_route_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && wr_i && addr_i == OFS_ROUTE) |=> $stable(route_o));

endmodule

// File: rtl/irqr_deliver.sv
module irqr_deliver #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned NOUT = 2,
    parameter int unsigned GBIT = NSRC - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           raw_i,
    input  logic [NSRC-1:0]           en_i,
    input  logic [NSRC-1:0]           route_i,
    output logic [NOUT-1:0][NSRC-1:0] mask_o,
    output logic [NOUT-1:0]           irq_o
);
    typedef struct packed {
        logic [NOUT-1:0] irq;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    gate;

    assign gate = en_i[GBIT];

    genvar n;
    generate
        for (n = 0; n < int'(NOUT); n++) begin : g_out
            if (n == 0) begin : g_lo
                assign mask_o[n] = raw_i & en_i & ~route_i;
            end else begin : g_hi
                assign mask_o[n] = raw_i & en_i & route_i;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < int'(NOUT); k++) begin
            st_d.irq[k] = gate && (|mask_o[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i[GBIT] |=> (irq_o == '0));

    p_out0_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i[GBIT] && (|(raw_i & en_i & ~route_i))) |=> irq_o[0]);

    p_out0_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_i & ~route_i) == '0) |=> !irq_o[0]);

endmodule

// File: rtl/irqr_dispatch.sv
module irqr_dispatch #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  mask_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = int'(NSRC) - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o   = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end

    p_disp_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> mask_i[idx_o]);

    p_disp_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((mask_i & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0));

    p_disp_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !valid_o);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irqr_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned IDX_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic [1:0]        cpu_irq,
    output logic              disp_valid,
    output logic [IDX_W-1:0]  disp_idx
);
    localparam int unsigned NOUT = 2;
    localparam int unsigned GBIT = NSRC - 1;

    logic [NSRC-1:0]           raw;
    logic [NSRC-1:0]           en;
    logic [NSRC-1:0]           route;
    logic [NOUT-1:0][NSRC-1:0] mask;

    irqr_sync #(.NSRC(NSRC), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (irq_src),
        .raw_o (raw)
    );

    irqr_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .raw_i   (raw),
        .mask0_i (mask[0]),
        .mask1_i (mask[1]),
        .en_o    (en),
        .route_o (route),
        .rdata_o (bus_rdata)
    );

    irqr_deliver #(.NSRC(NSRC), .NOUT(NOUT), .GBIT(GBIT)) u_deliver (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw),
        .en_i    (en),
        .route_i (route),
        .mask_o  (mask),
        .irq_o   (cpu_irq)
    );

    irqr_dispatch #(.NSRC(NSRC), .IDX_W(IDX_W)) u_dispatch (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_i  (mask[0]),
        .valid_o (disp_valid),
        .idx_o   (disp_idx)
    );

    // R6: the two masked views never claim the same source
    p_views_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[0] & mask[1]) == '0);

endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cpu_irq;
    logic        disp_valid;
    logic [4:0]  disp_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit [31:0] pipe[$];
    bit [31:0] m_en, m_type;
    bit [1:0]  m_irq;

    always #(TCLK/2) clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .disp_valid(disp_valid), .disp_idx(disp_idx)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_view(input int outn);
        bit [31:0] v = '0;
        for (int i = 0; i < 32; i++)
            if (pipe[0][i] && m_en[i] && (int'(m_type[i]) == outn)) v[i] = 1'b1;
        return v;
    endfunction

    function automatic bit [31:0] m_read(input bit [7:0] a);
        case (a)
            8'h00: return m_view(0);
            8'h04: return m_view(1);
            8'h20: return m_type;
            8'h30: return pipe[0];
            8'h34: return m_en;
            default: return '0;
        endcase
    endfunction

    function automatic string read_req(input bit [7:0] a);
        case (a)
            8'h00, 8'h04: return "R6";
            8'h20: return "R5";
            8'h30: return "R2";
            8'h34: return "R3";
            8'h38: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic compare_all();
        bit [31:0] v0;
        bit [31:0] er;
        er = (bus_sel && !bus_wr) ? m_read(bus_addr) : 32'h0;
        chk(read_req(bus_addr), "rdata", bus_rdata, er);
        chk(m_en[31] ? "R7" : "R8", "cpu_irq", cpu_irq, m_irq);
        v0 = m_view(0);
        chk("R9", "disp_valid", disp_valid, v0 != 0);
        if (v0 != 0) begin
            int lo = 0;
            for (int i = 31; i >= 0; i--) if (v0[i]) lo = i;
            chk("R9", "disp_idx", disp_idx, lo);
        end
    endtask

    task automatic model_edge();
        bit [31:0] v0, v1;
        v0 = m_view(0);
        v1 = m_view(1);
        m_irq[0] = m_en[31] && (v0 != 0);
        m_irq[1] = m_en[31] && (v1 != 0);
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                8'h34: m_en = m_en | bus_wdata;
                8'h38: m_en = m_en & ~bus_wdata;
                8'h20: m_type = bus_wdata;
                default: ;
            endcase
        end
        pipe.push_back(irq_src);
        void'(pipe.pop_front());
    endtask

    task automatic cyc(input bit [31:0] s, input bit sel, input bit wr,
                       input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        irq_src = s; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #2;
        compare_all();
        @(posedge clk);
        model_edge();
    endtask

    bit [31:0] cur_src = '0;

    task automatic wr_reg(input bit [7:0] a, input bit [31:0] d);
        cyc(cur_src, 1'b1, 1'b1, a, d);
    endtask
    task automatic rd_reg(input bit [7:0] a);
        cyc(cur_src, 1'b1, 1'b0, a, 32'h0);
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(cur_src, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        pipe = {32'h0, 32'h0};
        m_en = '0; m_type = '0; m_irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #2;
        chk("R1", "cpu_irq", cpu_irq, 0);
        chk("R1", "disp_valid", disp_valid, 0);
        rd_reg(8'h34); #2; chk("R1", "enable", bus_rdata, 0);
        rd_reg(8'h20); #2; chk("R1", "route", bus_rdata, 0);
        rd_reg(8'h30); rd_reg(8'h00); rd_reg(8'h04);

        // R2: raw follows inputs after the synchronizer; nothing enabled yet
        cur_src = 32'h0000_0201;
        rd_reg(8'h30); rd_reg(8'h30); rd_reg(8'h30); idle(1);

        // R3: set enables with global bit; zeros leave bits alone
        wr_reg(8'h34, 32'h8000_0201);
        rd_reg(8'h34); idle(2);
        wr_reg(8'h34, 32'h0000_0010);
        rd_reg(8'h34); rd_reg(8'h00);

        // R5: move source 0 to output 1; dispatch index moves to 9
        wr_reg(8'h20, 32'h0000_0001);
        rd_reg(8'h20); rd_reg(8'h00); rd_reg(8'h04); idle(2);

        // R6: writes to masked views are discarded
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_reg(8'h00); rd_reg(8'h04); rd_reg(8'h34); rd_reg(8'h20);

        // R8: drop the global gate, sources unchanged
        wr_reg(8'h38, 32'h8000_0000);
        idle(2); rd_reg(8'h00); rd_reg(8'h38);
        wr_reg(8'h34, 32'h8000_0000);
        idle(2);

        // R10: release source 9 only; output 0 must fall
        cur_src = 32'h0000_0001;
        idle(3); #2;
        chk("R10", "cpu_irq0", cpu_irq[0], 0);
        chk("R10", "cpu_irq1", cpu_irq[1], 1);
        idle(1);

        // R9: walking one across every position, all routed to output 0
        wr_reg(8'h20, 32'h0);
        wr_reg(8'h34, 32'hFFFF_FFFF);
        for (int b = 0; b < 32; b++) begin
            cur_src = 32'h1 << b;
            idle(3);
        end
        cur_src = 32'hFFFF_FFFF; idle(3);
        cur_src = 32'h8000_0000; idle(3);
        cur_src = 32'h0001_8000; idle(3); rd_reg(8'h00);

        // R11: unmapped offsets
        wr_reg(8'h10, 32'hFFFF_FFFF);
        wr_reg(8'h3C, 32'h0);
        rd_reg(8'h10); rd_reg(8'h3C); rd_reg(8'h34); rd_reg(8'h20);

        // R4: clear everything
        wr_reg(8'h38, 32'hFFFF_FFFF);
        rd_reg(8'h34); idle(2); #2;
        chk("R4", "cpu_irq after clear", cpu_irq, 0);
        cur_src = '0; idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule